// File: doc/BRIEF.md
# Convergence and Self-Adaptive Iteration Controller

This block runs the outer loop of an iterative message-passing decoder. It leaves the belief computation to an external engine. On `start` it takes in its configuration. For each iteration it pulses `iter_go` and waits for the engine to raise `iter_done`. It then walks the belief memory, one belief per clock. For each belief it compares the fresh value with the value the belief had after the previous iteration, which the block keeps in its own store. It records one stability flag per belief.

The walk ends in a decision. When every belief is stable, decoding stops early. When the iteration limit is reached, decoding also stops. Otherwise the block starts another iteration. In adaptive mode the block also pushes moving beliefs along their trend. It writes back a belief that rose by more than the threshold as V + V/8, and a belief that fell by more than the threshold as V − V/8. When the block finishes it pulses `done` and reports how many iterations it used.

The controller is a six-state machine:
- IDLE waits for `start`.
- KICK pulses `iter_go` and advances the iteration count.
- WAIT holds until `iter_done`.
- SCAN visits beliefs 0 to NB−1.
- DECIDE picks between KICK and FIN.
- FIN pulses `done` and returns to IDLE.

Transitions:
- IDLE→KICK on start.
- KICK→WAIT always.
- WAIT→SCAN on iter_done.
- SCAN→DECIDE after the last belief.
- DECIDE→FIN when all beliefs are stable or the limit is reached.
- DECIDE→KICK otherwise.
- FIN→IDLE always.

Top module: `conv_iter_ctrl`

## Requirements
- R1: After reset `done`, `iter_go` and `bel_we` are low and `iters_used` is 0.
- R2: Each iteration begins with a one-cycle `iter_go` pulse. The controller then waits for `iter_done` and reads beliefs at `bel_addr` 0 to NB−1, one per clock. The number of `iter_go` pulses in a run equals `iters_used` at `done`.
- R3: The iteration limit is `cfg_max_iter` when it is 1 to 5. A value of 0 selects 3, and a value above 5 selects 5. A run never issues more iterations than its limit.
- R4: In iterations 2 and later, belief i is stable when |V − Vprev| ≤ |Vprev| >> `cfg_eps_shift` (floor). All flags are cleared before every scan, so only the current iteration decides.
- R5: In the first iteration no belief is stable and nothing is written back. Every value read is stored as the previous value.
- R6: When every belief is stable after a scan, the run finishes at once, even below the limit.
- R7: `done` is a one-cycle pulse, and `iters_used` holds the iteration count until the next `start`.
- R8: In adaptive mode (`cfg_adaptive`=1), a belief with V − Vprev > threshold is written back as V + (V >>> 3), saturated to the W-bit signed range.
- R9: In adaptive mode, a belief with V − Vprev < −threshold is written back as V − (V >>> 3), saturated to the W-bit signed range.
- R10: With `cfg_adaptive`=0, `bel_we` stays low and beliefs are never altered.
- R11: The stored previous value of a belief is the value after any write-back, so the next comparison is made against the scaled value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decoding run (taken in IDLE) |
| cfg_adaptive | input | 1 | 1 = rescale moving beliefs |
| cfg_max_iter | input | 3 | Requested iteration limit |
| cfg_eps_shift | input | 4 | Threshold as a right shift of abs(Vprev) |
| iter_go | output | 1 | Pulse: engine runs one iteration |
| iter_done | input | 1 | Engine finished the iteration |
| bel_addr | output | 3 | Belief index being examined |
| bel_rdata | input | 16 | Belief value at bel_addr (same cycle) |
| bel_we | output | 1 | Write back a rescaled belief |
| bel_wdata | output | 16 | Rescaled belief value |
| done | output | 1 | Pulse: run finished |
| iters_used | output | 3 | Iterations issued in the run |

## Verification
The assertions assume that the engine raises `iter_done` only while the controller waits after an `iter_go`. They also assume that `bel_rdata` is valid in the same cycle as `bel_addr` and stays steady until the edge that writes it. The bench engine meets both assumptions: it answers each `iter_go` with one delayed `iter_done`, loads the next scripted belief set on that same edge, and serves reads combinationally from its array. `start` is raised only while the controller is idle.

// File: rtl/conv_pkg.sv
package conv_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_KICK,
        S_WAIT,
        S_SCAN,
        S_DECIDE,
        S_FIN
    } ctrl_state_t;
endpackage

// File: rtl/conv_eval.sv
module conv_eval #(
    parameter int W        = 16,
    parameter int SHW      = 4,
    parameter int SCALE_SH = 3
) (
    input  logic signed [W-1:0] cur,
    input  logic signed [W-1:0] prev,
    input  logic                first,
    input  logic                adaptive,
    input  logic [SHW-1:0]      eps_shift,
    output logic                stable,
    output logic                scale,
    output logic signed [W-1:0] adj
);
    localparam int XW = W + 2;
    localparam logic signed [XW-1:0] MAXV = XW'((1 << (W - 1)) - 1);
    localparam logic signed [XW-1:0] MINV = -MAXV - XW'(1);

    logic signed [XW-1:0] cur_x, prev_x, diff, mag_d, mag_p, lim;
    logic signed [XW-1:0] step, grow, shrink, pick;
    logic                 rising, falling;

    always_comb begin
        cur_x   = {{2{cur[W-1]}}, cur};
        prev_x  = {{2{prev[W-1]}}, prev};
        diff    = cur_x - prev_x;
        mag_d   = diff[XW-1] ? -diff : diff;
        mag_p   = prev_x[XW-1] ? -prev_x : prev_x;
        lim     = mag_p >>> eps_shift;
        stable  = !first && (mag_d <= lim);
        rising  = !first && !stable && !diff[XW-1];
        falling = !first && !stable && diff[XW-1];
        step    = cur_x >>> SCALE_SH;
        grow    = cur_x + step;
        shrink  = cur_x - step;
        pick    = rising ? grow : shrink;
        scale   = adaptive && (rising || falling);
        if (!scale)          adj = cur;
        else if (pick > MAXV) adj = MAXV[W-1:0];
        else if (pick < MINV) adj = MINV[W-1:0];
        else                  adj = pick[W-1:0];
        assert_dir_excl_R8: assert (!(rising && falling));
    end
endmodule

// File: rtl/conv_prev_store.sv
module conv_prev_store #(
    parameter int W  = 16,
    parameter int NB = 8,
    localparam int AW = $clog2(NB)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       addr,
    input  logic signed [W-1:0] wdata,
    output logic signed [W-1:0] rdata
);
    logic signed [W-1:0] mem_q [NB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NB; k++) mem_q[k] <= '0;
        end else if (wr_en) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

    assert_prev_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(addr)] == $past(wdata));
endmodule

// File: rtl/conv_stab_flags.sv
module conv_stab_flags #(
    parameter int NB = 8,
    localparam int AW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  logic          stable,
    output logic          all_stable
);
    logic [NB-1:0] flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_q <= '0;
        else if (clear)  flag_q <= '0;
        else if (wr_en)  flag_q[idx] <= stable;
    end

    assign all_stable = &flag_q;

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !all_stable);
endmodule

// File: rtl/conv_iter_ctrl.sv
module conv_iter_ctrl #(
    parameter int W         = 16,
    parameter int NB        = 8,
    parameter int ITER_CAP  = 5,
    parameter int ITER_DFLT = 3,
    parameter int SHW       = 4,
    parameter int SCALE_SH  = 3,
    localparam int AW = $clog2(NB),
    localparam int IW = $clog2(ITER_CAP + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cfg_adaptive,
    input  logic [IW-1:0]       cfg_max_iter,
    input  logic [SHW-1:0]      cfg_eps_shift,
    output logic                iter_go,
    input  logic                iter_done,
    output logic [AW-1:0]       bel_addr,
    input  logic signed [W-1:0] bel_rdata,
    output logic                bel_we,
    output logic signed [W-1:0] bel_wdata,
    output logic                done,
    output logic [IW-1:0]       iters_used
);
    import conv_pkg::*;

    localparam logic [AW-1:0] LAST_IDX = AW'(NB - 1);

    ctrl_state_t     state_q, state_d;
    logic [IW-1:0]   cnt_q, limit_q, limit_in;
    logic [AW-1:0]   idx_q;
    logic            mode_q;
    logic [SHW-1:0]  shift_q;
    logic            scan_en, first, clear_flags, all_stable;
    logic            stable, scale;
    logic signed [W-1:0] prev_val, adj;

    always_comb begin
        if (cfg_max_iter == '0)                 limit_in = IW'(ITER_DFLT);
        else if (cfg_max_iter > IW'(ITER_CAP))  limit_in = IW'(ITER_CAP);
        else                                    limit_in = cfg_max_iter;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_KICK;
            S_KICK:   state_d = S_WAIT;
            S_WAIT:   if (iter_done) state_d = S_SCAN;
            S_SCAN:   if (idx_q == LAST_IDX) state_d = S_DECIDE;
            S_DECIDE: state_d = (all_stable || cnt_q == limit_q) ? S_FIN : S_KICK;
            S_FIN:    state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            limit_q <= IW'(ITER_DFLT);
            idx_q   <= '0;
            mode_q  <= 1'b0;
            shift_q <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                cnt_q   <= '0;
                limit_q <= limit_in;
                mode_q  <= cfg_adaptive;
                shift_q <= cfg_eps_shift;
            end
            if (state_q == S_KICK) cnt_q <= cnt_q + IW'(1);
            if (state_q == S_WAIT) idx_q <= '0;
            else if (state_q == S_SCAN) idx_q <= idx_q + AW'(1);
        end
    end

    // outputs
    always_comb begin
        iter_go     = (state_q == S_KICK);
        scan_en     = (state_q == S_SCAN);
        done        = (state_q == S_FIN);
        clear_flags = (state_q == S_WAIT) && iter_done;
        bel_addr    = idx_q;
        first       = (cnt_q == IW'(1));
        bel_we      = scan_en && scale;
        bel_wdata   = adj;
        iters_used  = cnt_q;
    end

    conv_eval #(.W(W), .SHW(SHW), .SCALE_SH(SCALE_SH)) u_eval (
        .cur(bel_rdata), .prev(prev_val), .first(first), .adaptive(mode_q),
        .eps_shift(shift_q), .stable(stable), .scale(scale), .adj(adj)
    );

    conv_prev_store #(.W(W), .NB(NB)) u_prev (
        .clk(clk), .rst_n(rst_n), .wr_en(scan_en), .addr(idx_q),
        .wdata(adj), .rdata(prev_val)
    );

    conv_stab_flags #(.NB(NB)) u_flags (
        .clk(clk), .rst_n(rst_n), .clear(clear_flags), .wr_en(scan_en),
        .idx(idx_q), .stable(stable), .all_stable(all_stable)
    );

    assert_go_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iter_go |=> !iter_go);
    assert_iter_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iter_go |-> cnt_q < limit_q);
    assert_first_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bel_we |-> cnt_q >= IW'(2));
    assert_plain_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bel_we |-> mode_q);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (iters_used >= IW'(1)) && (iters_used <= limit_q));
endmodule

// File: tb/tb_conv_iter_ctrl.sv
module tb_conv_iter_ctrl;
    localparam int NB = 8;
    localparam int W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_adaptive = 1'b0;
    logic [2:0] cfg_max_iter = 3'd0;
    logic [3:0] cfg_eps_shift = 4'd0;
    logic iter_go, iter_done, bel_we, done;
    logic [2:0] bel_addr, iters_used;
    logic signed [W-1:0] bel_rdata, bel_wdata;

    always #2.5 clk = ~clk;

    conv_iter_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_adaptive(cfg_adaptive),
        .cfg_max_iter(cfg_max_iter), .cfg_eps_shift(cfg_eps_shift),
        .iter_go(iter_go), .iter_done(iter_done), .bel_addr(bel_addr),
        .bel_rdata(bel_rdata), .bel_we(bel_we), .bel_wdata(bel_wdata),
        .done(done), .iters_used(iters_used)
    );

    int checks = 0;
    int errors = 0;
    int seq [5][NB];
    logic signed [W-1:0] mem [NB];
    int eng_cnt = 0;
    int eng_it = 0;
    int go_cnt = 0;
    int fin_cnt = 0;

    assign bel_rdata = mem[bel_addr];

    // engine model: answers iter_go with the next scripted belief set
    initial iter_done = 1'b0;
    always @(posedge clk) begin
        if (start) eng_it <= 0;
        if (iter_go) eng_cnt <= 3;
        else if (eng_cnt != 0) eng_cnt <= eng_cnt - 1;
        iter_done <= (eng_cnt == 1) && !iter_go;
        if (eng_cnt == 1) begin
            for (int k = 0; k < NB; k++) mem[k] <= seq[eng_it][k][W-1:0];
            eng_it <= eng_it + 1;
        end
        if (bel_we) mem[bel_addr] <= bel_wdata;
    end

    typedef struct {
        string tag;
        int    iters;
        int    vals [NB];
    } exp_t;
    exp_t sb [$];

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    function automatic int sat(input int x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // monitor: pops expectations when the run finishes
    always @(negedge clk) begin
        if (rst_n && iter_go) go_cnt++;
        if (rst_n && done) begin
            exp_t e;
            bit ok;
            int bad;
            e = sb.pop_front();
            check(int'(iters_used) == e.iters, {e.tag, " iters R3 R6"}, int'(iters_used), e.iters);
            check(go_cnt == e.iters, {e.tag, " go pulses R2"}, go_cnt, e.iters);
            ok = 1'b1;
            bad = 0;
            for (int k = 0; k < NB; k++)
                if (int'(mem[k]) != e.vals[k]) begin
                    ok = 1'b0;
                    bad = k;
                end
            check(ok, {e.tag, " beliefs R8 R9 R10 R11"}, int'(mem[bad]), e.vals[bad]);
            fin_cnt++;
        end
    end

    // driver: reference model from the requirements, then start the run
    task automatic run_case(input string tag, input bit adp, input int mx, input int sh);
        exp_t e;
        int prev [NB];
        int lim, v, d, target;
        bit all_st;
        lim = (mx == 0) ? 3 : (mx > 5 ? 5 : mx);
        e.tag = tag;
        e.iters = 0;
        for (int it = 0; it < lim; it++) begin
            all_st = (it != 0);
            for (int i = 0; i < NB; i++) begin
                v = seq[it][i];
                if (it != 0) begin
                    d = v - prev[i];
                    if (iabs(d) > (iabs(prev[i]) >>> sh)) begin
                        all_st = 1'b0;
                        if (adp) v = (d > 0) ? sat(v + (v >>> 3)) : sat(v - (v >>> 3));
                    end
                end
                prev[i] = v;
                e.vals[i] = v;
            end
            e.iters = it + 1;
            if (all_st) break;
        end
        sb.push_back(e);
        target = fin_cnt + 1;
        @(negedge clk);
        go_cnt = 0;
        cfg_adaptive = adp;
        cfg_max_iter = mx[2:0];
        cfg_eps_shift = sh[3:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (fin_cnt == target);
        @(negedge clk);
        check(done == 1'b0, {tag, " done one cycle R7"}, int'(done), 0);
        check(int'(iters_used) == e.iters, {tag, " count held R7"}, int'(iters_used), e.iters);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < NB; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        check(!done && !iter_go && !bel_we && iters_used == 3'd0, "reset R1",
              int'({done, iter_go, bel_we, iters_used}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 constant beliefs: exit after the second iteration
        for (int it = 0; it < 5; it++) for (int i = 0; i < NB; i++) seq[it][i] = 100 + 10 * i;
        run_case("const R6", 1'b0, 5, 3);

        // R3 R10 moving beliefs, plain mode, limits 3 / 0->3 / 7->5
        for (int it = 0; it < 5; it++) for (int i = 0; i < NB; i++) seq[it][i] = 100 * (it + 1) + i;
        run_case("limit3 R3 R10", 1'b0, 3, 3);
        run_case("limit0 R3", 1'b0, 0, 3);
        run_case("limit7 R3", 1'b0, 7, 3);
        run_case("limit1 R5", 1'b1, 1, 3);

        // R8 adaptive rise
        for (int it = 0; it < 5; it++) for (int i = 0; i < NB; i++) seq[it][i] = 1000 * (it + 1) + i;
        run_case("rise R8", 1'b1, 2, 4);

        // R9 adaptive fall
        for (int it = 0; it < 5; it++) for (int i = 0; i < NB; i++) seq[it][i] = 4000 - 1000 * it - i;
        run_case("fall R9", 1'b1, 2, 4);

        // R8 R9 saturation and negative values
        for (int i = 0; i < NB; i++) begin seq[0][i] = 500; seq[1][i] = 500; end
        seq[0][0] = 20000;  seq[1][0] = 32000;
        seq[0][1] = -20000; seq[1][1] = -32000;
        seq[0][2] = -32000; seq[1][2] = -30000;
        seq[0][3] = 32000;  seq[1][3] = 20000;
        run_case("saturate R8 R9", 1'b1, 2, 4);

        // R4 boundary: change exactly equal to the threshold is stable
        for (int it = 0; it < 5; it++) for (int i = 0; i < NB; i++) seq[it][i] = 800;
        for (int it = 1; it < 5; it++) seq[it][0] = 900;
        run_case("edge equal R4", 1'b0, 5, 3);
        for (int it = 1; it < 5; it++) seq[it][0] = 901;
        run_case("edge over R4", 1'b0, 5, 3);

        // R4 zero previous value, zero change
        for (int it = 0; it < 5; it++) for (int i = 0; i < NB; i++) seq[it][i] = 0;
        run_case("zero R4", 1'b0, 5, 0);

        // R11 next comparison uses the scaled value
        for (int it = 0; it < 5; it++) for (int i = 0; i < NB; i++) seq[it][i] = 800;
        for (int it = 1; it < 5; it++) seq[it][0] = 1000;
        for (int it = 2; it < 5; it++) seq[it][0] = 1125;
        run_case("scaled prev R11", 1'b1, 5, 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule